// File: doc/BRIEF.md
# Calendar Periodic Event Flag Generator

This block watches a running time-of-day and date, supplied from outside together with a one-per-second strobe, and raises event flags when chosen boundaries are crossed. A time boundary (each minute, each hour, midnight or noon) and a calendar boundary (start of week, start of month or start of year) are each picked through a small select field. Two more flags come in as ready-made pulses: an alarm match and an update acknowledge.

The flags are kept in a five-bit status word. Software clears flags by writing ones to a clear word. Interrupt sources are turned on and off through separate enable and disable words, which act on a mask word that can be read back. A single interrupt line is high whenever a status flag is set and its mask bit is set.

All fields are plain binary. The weekday runs from 1 (Monday) to 7. The month runs from 1 (January) to 12. The date starts at 1. Hours run 0..23 in 24-hour mode and 1..12 with an AM/PM flag in 12-hour mode. On a strobe cycle the fields carry the time that has just been reached.

Top module: `cal_evt_gen`

## Requirements
- R1: After reset the status word, the mask word and the control word (both selects and the hour mode) read 0, and the interrupt line is low.
- R2: Every cycle with the second strobe high sets status bit 2 (second event). The time event and the calendar event are evaluated only in strobe cycles. Field values seen without a strobe set nothing.
- R3: A pulse on the alarm input sets status bit 1, and a pulse on the acknowledge input sets status bit 0.
- R4: Control bits [1:0] select the time event and set status bit 3 on a strobe. Value 0 fires when seconds = 0 (a minute boundary). Value 1 fires when seconds = 0 and minutes = 0 (an hour boundary).
- R5: In 24-hour mode (control bit 4 = 0), time select 2 fires at 00:00:00 and time select 3 fires at 12:00:00.
- R6: In 12-hour mode (control bit 4 = 1), midnight is hour 12, minute 0, second 0 with the PM flag low. Noon is the same time with the PM flag high.
- R7: Control bits [3:2] select the calendar event and set status bit 4 on a strobe at midnight, as midnight is defined by the hour mode. Value 0 fires when the weekday = 1. Value 1 fires when the date = 1. Value 2 fires when the date = 1 and the month = 1.
- R8: Calendar select 3 never sets status bit 4.
- R9: A write to the clear word (address 2) clears each status bit whose data bit is 1. Data bits that are 0 leave the status bit unchanged.
- R10: When a status bit is set and cleared in the same cycle, it ends up set.
- R11: A write to the enable word (address 3) sets mask bits, and a write to the disable word (address 4) clears them. Data bits that are 0 change nothing. The mask reads back at address 5. The control word is at address 0 and the status word at address 1. Write-only and unused addresses read 0.
- R12: The interrupt line is high exactly when some status bit and the mask bit at the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-per-second strobe |
| second | input | 6 | Current second, binary |
| minute | input | 6 | Current minute, binary |
| hour | input | 5 | Current hour, binary |
| pmFlag | input | 1 | PM indicator used in 12-hour mode |
| weekday | input | 3 | Weekday, 1 = Monday |
| date | input | 5 | Day of month, starting at 1 |
| month | input | 4 | Month, 1 = January |
| alarmPulse | input | 1 | Alarm match pulse |
| ackPulse | input | 1 | Update acknowledge pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 5 | Register write data |
| regRdData | output | 5 | Register read data for regAddr |
| irq | output | 1 | Interrupt line |

## Verification
The bench places strobes on the exact boundary times and on times just next to them: second zero with a nonzero minute under the hour select, 12:00:00 with the PM flag in both states, Monday versus Tuesday at midnight, and the first of a month other than January. A design that decoded the 12-hour midnight as hour 0, or ignored the PM flag, would flag noon and midnight the same way. A design that did not gate the calendar event on midnight would flag the whole day. The bench also aims a clear write at the same cycle as a strobe, so a design that let the clear win would lose the second flag. It writes all-zero clear, enable and disable words, which catch logic that assigns where it should only set or clear. Finally it holds boundary field values with no strobe, which exposes detection that is not gated by the strobe.

// File: rtl/cal_evt_pkg.sv
package cal_evt_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int ADDR_W    = 3;

  // status / mask bit positions
  localparam int FLAG_ACK = 0;
  localparam int FLAG_ALM = 1;
  localparam int FLAG_SEC = 2;
  localparam int FLAG_TIM = 3;
  localparam int FLAG_CAL = 4;

  // register addresses
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DIS  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd5;

  typedef enum logic [1:0] {
    TSEL_MINUTE   = 2'd0,
    TSEL_HOUR     = 2'd1,
    TSEL_MIDNIGHT = 2'd2,
    TSEL_NOON     = 2'd3
  } time_sel_e;

  typedef enum logic [1:0] {
    CSEL_WEEK  = 2'd0,
    CSEL_MONTH = 2'd1,
    CSEL_YEAR  = 2'd2,
    CSEL_NONE  = 2'd3
  } cal_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_FLAGS-1:0] setV;
    logic [NUM_FLAGS-1:0] clrV;
    logic [NUM_FLAGS-1:0] enV;
    logic [NUM_FLAGS-1:0] disV;
  } evt_strobe_t;
endpackage

// File: rtl/cal_evt_ctrl.sv
module cal_evt_ctrl
  import cal_evt_pkg::*;
#(
  parameter int SEC_W   = 6,
  parameter int MIN_W   = 6,
  parameter int HOUR_W  = 5,
  parameter int WDAY_W  = 3,
  parameter int DATE_W  = 5,
  parameter int MONTH_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 secTick,
  input  logic [SEC_W-1:0]     second,
  input  logic [MIN_W-1:0]     minute,
  input  logic [HOUR_W-1:0]    hour,
  input  logic                 pmFlag,
  input  logic [WDAY_W-1:0]    weekday,
  input  logic [DATE_W-1:0]    date,
  input  logic [MONTH_W-1:0]   month,
  input  logic                 alarmPulse,
  input  logic                 ackPulse,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_FLAGS-1:0] regWrData,
  output logic [NUM_FLAGS-1:0] ctrlWord,
  output evt_strobe_t          strobes
);
  localparam logic [HOUR_W-1:0]  HOUR_TWELVE = HOUR_W'(12);
  localparam logic [WDAY_W-1:0]  WDAY_MONDAY = WDAY_W'(1);
  localparam logic [DATE_W-1:0]  DATE_FIRST  = DATE_W'(1);
  localparam logic [MONTH_W-1:0] MONTH_JAN   = MONTH_W'(1);

  logic [NUM_FLAGS-1:0] ctrlQ;
  time_sel_e timeSel;
  cal_sel_e  calSel;
  logic      mode12;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (regWrEn && regAddr == ADDR_CTRL) ctrlQ <= regWrData;
  end

  assign timeSel  = time_sel_e'(ctrlQ[1:0]);
  assign calSel   = cal_sel_e'(ctrlQ[3:2]);
  assign mode12   = ctrlQ[4];
  assign ctrlWord = ctrlQ;

  // boundary decode
  logic secZero, topOfHour, isMidnight, isNoon, timeHit, calHit;

  always_comb begin
    secZero   = (second == '0);
    topOfHour = secZero && (minute == '0);
    if (mode12) begin
      isMidnight = topOfHour && (hour == HOUR_TWELVE) && !pmFlag;
      isNoon     = topOfHour && (hour == HOUR_TWELVE) &&  pmFlag;
    end else begin
      isMidnight = topOfHour && (hour == '0);
      isNoon     = topOfHour && (hour == HOUR_TWELVE);
    end

    unique case (timeSel)
      TSEL_MINUTE:   timeHit = secZero;
      TSEL_HOUR:     timeHit = topOfHour;
      TSEL_MIDNIGHT: timeHit = isMidnight;
      default:       timeHit = isNoon;
    endcase

    unique case (calSel)
      CSEL_WEEK:  calHit = isMidnight && (weekday == WDAY_MONDAY);
      CSEL_MONTH: calHit = isMidnight && (date == DATE_FIRST);
      CSEL_YEAR:  calHit = isMidnight && (date == DATE_FIRST) && (month == MONTH_JAN);
      default:    calHit = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    strobes.setV[FLAG_ACK] = ackPulse;
    strobes.setV[FLAG_ALM] = alarmPulse;
    strobes.setV[FLAG_SEC] = secTick;
    strobes.setV[FLAG_TIM] = secTick && timeHit;
    strobes.setV[FLAG_CAL] = secTick && calHit;
    if (regWrEn) begin
      if (regAddr == ADDR_CLR) strobes.clrV = regWrData;
      if (regAddr == ADDR_EN)  strobes.enV  = regWrData;
      if (regAddr == ADDR_DIS) strobes.disV = regWrData;
    end
  end
endmodule

// File: rtl/cal_evt_dp.sv
module cal_evt_dp
  import cal_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  evt_strobe_t          strobes,
  output logic [NUM_FLAGS-1:0] statusQ,
  output logic [NUM_FLAGS-1:0] maskQ,
  output logic                 irq
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[i] <= 1'b0;
        maskQ[i]   <= 1'b0;
      end else begin
        // a set in the same cycle as a clear takes precedence
        statusQ[i] <= strobes.setV[i] | (statusQ[i] & ~strobes.clrV[i]);
        maskQ[i]   <= (maskQ[i] | strobes.enV[i]) & ~strobes.disV[i];
      end
    end
  end

  assign irq = |(statusQ & maskQ);
endmodule

// File: rtl/cal_evt_gen.sv
module cal_evt_gen
  import cal_evt_pkg::*;
#(
  parameter int SEC_W   = 6,
  parameter int MIN_W   = 6,
  parameter int HOUR_W  = 5,
  parameter int WDAY_W  = 3,
  parameter int DATE_W  = 5,
  parameter int MONTH_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 secTick,
  input  logic [SEC_W-1:0]     second,
  input  logic [MIN_W-1:0]     minute,
  input  logic [HOUR_W-1:0]    hour,
  input  logic                 pmFlag,
  input  logic [WDAY_W-1:0]    weekday,
  input  logic [DATE_W-1:0]    date,
  input  logic [MONTH_W-1:0]   month,
  input  logic                 alarmPulse,
  input  logic                 ackPulse,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_FLAGS-1:0] regWrData,
  output logic [NUM_FLAGS-1:0] regRdData,
  output logic                 irq
);
  evt_strobe_t          strobes;
  logic [NUM_FLAGS-1:0] ctrlWord;
  logic [NUM_FLAGS-1:0] statusQ;
  logic [NUM_FLAGS-1:0] maskQ;

  cal_evt_ctrl #(
    .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
    .WDAY_W(WDAY_W), .DATE_W(DATE_W), .MONTH_W(MONTH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .second(second), .minute(minute), .hour(hour), .pmFlag(pmFlag),
    .weekday(weekday), .date(date), .month(month),
    .alarmPulse(alarmPulse), .ackPulse(ackPulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .ctrlWord(ctrlWord), .strobes(strobes)
  );

  cal_evt_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .statusQ(statusQ), .maskQ(maskQ), .irq(irq)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = ctrlWord;
      ADDR_STAT: regRdData = statusQ;
      ADDR_MASK: regRdData = maskQ;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/cal_evt_chk.sv
module cal_evt_chk
  import cal_evt_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 secTick,
  input logic                 alarmPulse,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [NUM_FLAGS-1:0] regWrData,
  input logic [NUM_FLAGS-1:0] ctrlWord,
  input logic [NUM_FLAGS-1:0] statusQ,
  input logic [NUM_FLAGS-1:0] maskQ,
  input logic                 irq
);
  logic clrWrite;
  assign clrWrite = regWrEn && (regAddr == ADDR_CLR);

  AST_TICK_SETS_SEC: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> statusQ[FLAG_SEC]); // R2
  AST_NO_TICK_NO_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !clrWrite) |=> $stable(statusQ[FLAG_CAL:FLAG_SEC])); // R2
  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |=> statusQ[FLAG_ALM]); // R3
  AST_RESERVED_CAL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[3:2] == 2'd3 && !statusQ[FLAG_CAL]) |=> !statusQ[FLAG_CAL]); // R8
  AST_CLEAR_TIME_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && regWrData[FLAG_TIM] && !secTick) |=> !statusQ[FLAG_TIM]); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && clrWrite && regWrData[FLAG_SEC]) |=> statusQ[FLAG_SEC]); // R10
  AST_ENABLE_SETS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_EN && regWrData[FLAG_ACK]) |=> maskQ[FLAG_ACK]); // R11
  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq); // R12
endmodule

bind cal_evt_gen cal_evt_chk u_chk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .alarmPulse(alarmPulse),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .ctrlWord(ctrlWord), .statusQ(statusQ), .maskQ(maskQ), .irq(irq)
);

// File: tb/cal_evt_gen_tb.sv
`timescale 1ns/1ps
module cal_evt_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [5:0] second = '0;
  logic [5:0] minute = '0;
  logic [4:0] hour = '0;
  logic       pmFlag = 1'b0;
  logic [2:0] weekday = 3'd3;
  logic [4:0] date = 5'd15;
  logic [3:0] month = 4'd6;
  logic       alarmPulse = 1'b0;
  logic       ackPulse = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [4:0] regWrData = '0;
  logic [4:0] regRdData;
  logic       irq;

  always #2.5 clk = ~clk;

  cal_evt_gen u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .second(second), .minute(minute), .hour(hour), .pmFlag(pmFlag),
    .weekday(weekday), .date(date), .month(month),
    .alarmPulse(alarmPulse), .ackPulse(ackPulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // scoreboard queues
  logic [4:0] expDataQ[$];
  logic       expIrqQ[$];
  string      tagQ[$];
  logic       sampleReq = 1'b0;

  always @(negedge clk) begin
    if (sampleReq && expDataQ.size() > 0) begin
      logic [4:0] ed;
      logic       ei;
      string      tg;
      ed = expDataQ.pop_front();
      ei = expIrqQ.pop_front();
      tg = tagQ.pop_front();
      checks++;
      if (regRdData !== ed || irq !== ei) begin
        failures++;
        $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                 tg, regRdData, irq, ed, ei);
      end
    end
  end

  task automatic expectRead(input logic [2:0] a, input logic [4:0] d,
                            input logic i, input string tg);
    @(posedge clk); #1;
    regAddr = a;
    expDataQ.push_back(d);
    expIrqQ.push_back(i);
    tagQ.push_back(tg);
    sampleReq = 1'b1;
    @(posedge clk); #1;
    sampleReq = 1'b0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [4:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic setTime(input int h, input int m, input int s, input bit pm,
                         input int wd, input int dt, input int mo);
    hour = 5'(h); minute = 6'(m); second = 6'(s); pmFlag = pm;
    weekday = 3'(wd); date = 5'(dt); month = 4'(mo);
  endtask

  task automatic tick(input int h, input int m, input int s, input bit pm,
                      input int wd, input int dt, input int mo);
    @(posedge clk); #1;
    setTime(h, m, s, pm, wd, dt, mo);
    secTick = 1'b1;
    @(posedge clk); #1;
    secTick = 1'b0;
    setTime(3, 17, 41, 0, 3, 15, 6);
  endtask

  task automatic clearAll();
    writeReg(3'd2, 5'h1F);
  endtask

  // tick then status read then clear
  task automatic tickExpect(input int h, input int m, input int s, input bit pm,
                            input int wd, input int dt, input int mo,
                            input logic [4:0] exp, input string tg);
    tick(h, m, s, pm, wd, dt, mo);
    expectRead(3'd1, exp, 1'b0, tg);
    clearAll();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectRead(3'd0, 5'h00, 1'b0, "R1 control after reset");
    expectRead(3'd1, 5'h00, 1'b0, "R1 status after reset");
    expectRead(3'd5, 5'h00, 1'b0, "R1 mask after reset");

    // R2 second event, no other event off boundary
    tick(10, 20, 30, 0, 3, 15, 6);
    expectRead(3'd1, 5'h04, 1'b0, "R2 tick sets second flag only");
    // R9 zero clear has no effect, then clear the bit
    writeReg(3'd2, 5'h00);
    expectRead(3'd1, 5'h04, 1'b0, "R9 zero clear keeps status");
    writeReg(3'd2, 5'h04);
    expectRead(3'd1, 5'h00, 1'b0, "R9 clear bit2");

    // R3 pulses
    @(posedge clk); #1 alarmPulse = 1'b1;
    @(posedge clk); #1 alarmPulse = 1'b0;
    expectRead(3'd1, 5'h02, 1'b0, "R3 alarm flag");
    @(posedge clk); #1 ackPulse = 1'b1;
    @(posedge clk); #1 ackPulse = 1'b0;
    expectRead(3'd1, 5'h03, 1'b0, "R3 ack flag added");
    writeReg(3'd2, 5'h01);
    expectRead(3'd1, 5'h02, 1'b0, "R9 clear only bit0");
    clearAll();

    // R2 boundary fields without strobe
    @(posedge clk); #1 setTime(0, 0, 0, 0, 1, 1, 1);
    repeat (3) @(posedge clk);
    expectRead(3'd1, 5'h00, 1'b0, "R2 no strobe no event");

    // R4 minute and hour selects
    tickExpect(10, 21, 0, 0, 3, 15, 6, 5'h0C, "R4 minute boundary");
    writeReg(3'd0, 5'h01);
    expectRead(3'd0, 5'h01, 1'b0, "R11 control readback");
    tickExpect(10, 22, 0, 0, 3, 15, 6, 5'h04, "R4 hour sel ignores minute");
    tickExpect(11, 0, 0, 0, 3, 15, 6, 5'h0C, "R4 hour boundary");

    // R5 24-hour midnight/noon
    writeReg(3'd0, 5'h02);
    tickExpect(12, 0, 0, 0, 3, 15, 6, 5'h04, "R5 midnight sel at noon");
    tickExpect(0, 0, 0, 0, 3, 15, 6, 5'h0C, "R5 midnight");
    writeReg(3'd0, 5'h03);
    tickExpect(0, 0, 0, 0, 3, 15, 6, 5'h04, "R5 noon sel at midnight");
    tickExpect(12, 0, 0, 0, 3, 15, 6, 5'h0C, "R5 noon");

    // R6 12-hour mode
    writeReg(3'd0, 5'h13);
    tickExpect(12, 0, 0, 0, 3, 15, 6, 5'h04, "R6 noon sel 12 AM");
    tickExpect(12, 0, 0, 1, 3, 15, 6, 5'h0C, "R6 noon 12 PM");
    writeReg(3'd0, 5'h12);
    tickExpect(12, 0, 0, 0, 3, 15, 6, 5'h0C, "R6 midnight 12 AM");
    tickExpect(12, 0, 0, 1, 3, 15, 6, 5'h04, "R6 midnight sel 12 PM");
    tickExpect(0, 0, 0, 0, 3, 15, 6, 5'h04, "R6 hour 0 not midnight in 12h");

    // R7 calendar selects (time select 0 also fires at sec 0)
    writeReg(3'd0, 5'h00);
    tickExpect(0, 0, 0, 0, 1, 15, 6, 5'h1C, "R7 Monday midnight");
    tickExpect(0, 0, 0, 0, 2, 15, 6, 5'h0C, "R7 Tuesday midnight");
    tickExpect(1, 0, 0, 0, 1, 15, 6, 5'h0C, "R7 Monday not midnight");
    writeReg(3'd0, 5'h04);
    tickExpect(0, 0, 0, 0, 3, 1, 6, 5'h1C, "R7 first of month");
    tickExpect(0, 0, 0, 0, 3, 2, 6, 5'h0C, "R7 second of month");
    writeReg(3'd0, 5'h08);
    tickExpect(0, 0, 0, 0, 3, 1, 1, 5'h1C, "R7 January first");
    tickExpect(0, 0, 0, 0, 3, 1, 2, 5'h0C, "R7 February first");
    writeReg(3'd0, 5'h14);
    tickExpect(12, 0, 0, 0, 3, 1, 6, 5'h1C, "R7 month in 12h mode");
    tickExpect(0, 0, 0, 0, 3, 1, 6, 5'h0C, "R7 12h hour 0 not midnight");

    // R8 reserved calendar select
    writeReg(3'd0, 5'h0C);
    tickExpect(0, 0, 0, 0, 1, 1, 1, 5'h0C, "R8 reserved calendar select");

    // R10 set wins over clear in same cycle
    @(posedge clk); #1;
    setTime(4, 5, 6, 0, 3, 15, 6);
    secTick = 1'b1; regWrEn = 1'b1; regAddr = 3'd2; regWrData = 5'h1F;
    @(posedge clk); #1;
    secTick = 1'b0; regWrEn = 1'b0; regWrData = '0;
    expectRead(3'd1, 5'h04, 1'b0, "R10 set beats clear");
    clearAll();

    // R11 mask enable/disable
    writeReg(3'd3, 5'h06);
    expectRead(3'd5, 5'h06, 1'b0, "R11 enable");
    writeReg(3'd4, 5'h02);
    expectRead(3'd5, 5'h04, 1'b0, "R11 disable");
    writeReg(3'd3, 5'h00);
    writeReg(3'd4, 5'h00);
    expectRead(3'd5, 5'h04, 1'b0, "R11 zero writes no effect");
    expectRead(3'd3, 5'h00, 1'b0, "R11 write-only reads zero");

    // R12 interrupt line
    tick(4, 5, 7, 0, 3, 15, 6);
    expectRead(3'd1, 5'h04, 1'b1, "R12 masked-in flag drives irq");
    writeReg(3'd4, 5'h04);
    expectRead(3'd1, 5'h04, 1'b0, "R12 masked-out flag no irq");
    writeReg(3'd3, 5'h02);
    expectRead(3'd1, 5'h04, 1'b0, "R12 enabled bit without flag");
    @(posedge clk); #1 alarmPulse = 1'b1;
    @(posedge clk); #1 alarmPulse = 1'b0;
    expectRead(3'd1, 5'h06, 1'b1, "R12 alarm raises irq");
    writeReg(3'd2, 5'h02);
    expectRead(3'd1, 5'h04, 1'b0, "R12 clear drops irq");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule